// File: doc/BRIEF.md
# Coded Flash Command Sequencer

This block sits behind a flash device's bus interface and turns the stream of latched write cycles into operations. Every instruction must open with two fixed unlock writes (a known data value at a known address, twice), followed by a command write. Program then takes one more write carrying the target address and data. Block and chip erase repeat the two unlock writes before a confirm write on the sixth cycle. A write that breaks any sequence drops the decoder back to reading the array.

The sequencer emits one-cycle strobes toward a program/erase controller: start program, start erase (block or whole chip), suspend and resume. It tracks what that controller is doing by watching its busy flag. It also drives a read-mode select that tells the read path to return array data, identifier codes or status. While an operation runs, every write is ignored except the single-write erase-suspend command. While an erase is suspended, programs and a single-write resume are accepted. All unlock addresses, unlock data and command codes are parameters.

Top module: `flash_cmd_sequencer`

## Requirements
- R1: A high `rst` at a rising edge clears all pending sequence progress and the identifier mode, so the next cycle shows no strobes and `read_mode` 0 while `pec_busy` is low. A write sequence that was interrupted by reset does not complete afterwards.
- R2: The program sequence works as follows. Write KEY1_DATA at KEY1_ADDR, then KEY2_DATA at KEY2_ADDR, then CMD_PROGRAM at KEY1_ADDR, then any address/data pair. This raises `pgm_go` for one cycle, in the cycle after the fourth write. `op_addr` and `op_data` then hold that pair until the next accepted operation.
- R3: An erase sequence is the two unlock writes, CMD_ERASE at KEY1_ADDR, and the two unlock writes again. A sixth write of CMD_BLOCK at any address then raises `ers_go` with `ers_all` low, and `op_addr` is that address. A sixth write of CMD_CHIP at KEY1_ADDR raises `ers_go` with `ers_all` high. `ers_all` is never high without `ers_go`.
- R4: A write whose address or data deviates at any position of a sequence produces no strobe. It returns `read_mode` to 0 (array), and a correct sequence that follows is accepted from its first write.
- R5: The two unlock writes followed by CMD_IDENT at KEY1_ADDR set `read_mode` to 1 (identifier). That mode stays until a single CMD_RESET write, a broken sequence or a completed operation returns it to 0.
- R6: `read_mode` encodes 0 = array, 1 = identifier, 2 = status. It is 2 whenever `pec_busy` is high, and from the cycle a program, erase or resume strobe is issued until the next falling edge of `pec_busy`.
- R7: While an operation is in progress (`pec_busy` high or an issued operation not yet ended), writes produce no strobe. The exception is a single write of CMD_SUSPEND at any address during a running erase, which raises `susp_go` the next cycle.
- R8: While an erase is suspended and `pec_busy` is low, a program sequence is accepted and an erase sequence is rejected at its command write. A single write of CMD_RESUME at any address raises `resm_go` and returns `read_mode` to status.
- R9: CMD_SUSPEND written during a program does not raise `susp_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One latched bus write this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| pec_busy | input | 1 | Program/erase controller busy |
| pgm_go | output | 1 | Start-program strobe |
| ers_go | output | 1 | Start-erase strobe |
| ers_all | output | 1 | Qualifies `ers_go` as chip erase |
| susp_go | output | 1 | Erase-suspend strobe |
| resm_go | output | 1 | Erase-resume strobe |
| op_addr | output | AW | Address of the last issued program/erase |
| op_data | output | DW | Data of the last issued program/erase |
| read_mode | output | 2 | 0 array, 1 identifier, 2 status |

## Verification
Each strobe, together with `op_addr` and `op_data`, is due in the cycle right after the rising edge that samples the final write of its sequence: one register stage. `read_mode` follows `pec_busy` in the same cycle and follows the decoder state one cycle after the write. The bench drives inputs on falling edges. It advances its behavioural model on each rising edge and compares every output 2 ns later, so every expected value is checked in exactly the cycle it becomes due. Counted strobes are also checked after each scenario, including the loop that corrupts one write at each position of the program and erase sequences.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PGM_DATA,
        SQ_ERS_ARM,
        SQ_ERS_KEY1,
        SQ_ERS_KEY2
    } seq_t;

    typedef enum logic [2:0] {
        RUN_NONE,
        RUN_PGM,
        RUN_ERS,
        RUN_SUSP,
        RUN_SUSP_PGM
    } run_t;

    typedef struct packed {
        logic pgm;
        logic ers;
        logic chip;
        logic susp;
        logic resm;
    } issue_t;

    localparam logic [1:0] RDM_ARRAY  = 2'd0;
    localparam logic [1:0] RDM_IDENT  = 2'd1;
    localparam logic [1:0] RDM_STATUS = 2'd2;

    function automatic logic run_active(run_t r);
        return (r == RUN_PGM) || (r == RUN_ERS) || (r == RUN_SUSP_PGM);
    endfunction

endpackage

// File: rtl/fcs_seq_decode.sv
module fcs_seq_decode
    import fcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 8,
    parameter logic [AW-1:0] KEY1_ADDR = 'h555,
    parameter logic [AW-1:0] KEY2_ADDR = 'h2AA,
    parameter logic [DW-1:0] KEY1_DATA = 'hAA,
    parameter logic [DW-1:0] KEY2_DATA = 'h55,
    parameter logic [DW-1:0] CMD_RESET   = 'hF0,
    parameter logic [DW-1:0] CMD_IDENT   = 'h90,
    parameter logic [DW-1:0] CMD_PROGRAM = 'hA0,
    parameter logic [DW-1:0] CMD_ERASE   = 'h80,
    parameter logic [DW-1:0] CMD_CHIP    = 'h10,
    parameter logic [DW-1:0] CMD_BLOCK   = 'h30,
    parameter logic [DW-1:0] CMD_SUSPEND = 'hB0,
    parameter logic [DW-1:0] CMD_RESUME  = 'h30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          engaged,
    input  logic          run_ers,
    input  logic          run_susp,
    output issue_t        issue,
    output logic          ident
);

    seq_t seq, seq_n;
    logic ident_n;
    logic hit1, hit2, at1;

    assign hit1 = (wr_addr == KEY1_ADDR) && (wr_data == KEY1_DATA);
    assign hit2 = (wr_addr == KEY2_ADDR) && (wr_data == KEY2_DATA);
    assign at1  = (wr_addr == KEY1_ADDR);

    always_comb begin
        seq_n   = seq;
        ident_n = ident;
        issue   = '0;
        if (wr_en) begin
            if (engaged) begin
                seq_n      = SQ_IDLE;
                issue.susp = (wr_data == CMD_SUSPEND) && run_ers;
            end else begin
                // default outcome of a write: abandon and read the array
                seq_n   = SQ_IDLE;
                ident_n = 1'b0;
                case (seq)
                    SQ_IDLE: begin
                        if (wr_data == CMD_RESET) begin
                            ident_n = 1'b0;
                        end else if (run_susp && (wr_data == CMD_RESUME)) begin
                            issue.resm = 1'b1;
                            ident_n    = ident;
                        end else if (hit1) begin
                            seq_n   = SQ_KEY1;
                            ident_n = ident;
                        end
                    end
                    SQ_KEY1: if (hit2) begin
                        seq_n   = SQ_KEY2;
                        ident_n = ident;
                    end
                    SQ_KEY2: if (at1) begin
                        if (wr_data == CMD_IDENT) begin
                            ident_n = 1'b1;
                        end else if (wr_data == CMD_PROGRAM) begin
                            seq_n   = SQ_PGM_DATA;
                            ident_n = ident;
                        end else if ((wr_data == CMD_ERASE) && !run_susp) begin
                            seq_n   = SQ_ERS_ARM;
                            ident_n = ident;
                        end
                    end
                    SQ_PGM_DATA: issue.pgm = 1'b1;
                    SQ_ERS_ARM: if (hit1) begin
                        seq_n   = SQ_ERS_KEY1;
                        ident_n = ident;
                    end
                    SQ_ERS_KEY1: if (hit2) begin
                        seq_n   = SQ_ERS_KEY2;
                        ident_n = ident;
                    end
                    SQ_ERS_KEY2: begin
                        if ((wr_data == CMD_CHIP) && at1) begin
                            issue.ers  = 1'b1;
                            issue.chip = 1'b1;
                        end else if (wr_data == CMD_BLOCK) begin
                            issue.ers = 1'b1;
                        end
                    end
                    default: seq_n = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq   <= SQ_IDLE;
            ident <= 1'b0;
        end else begin
            seq   <= seq_n;
            ident <= ident_n;
        end
    end

endmodule

// File: rtl/fcs_run_track.sv
module fcs_run_track
    import fcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pec_busy,
    input  logic issue_pgm,
    input  logic issue_ers,
    input  logic issue_susp,
    input  logic issue_resm,
    output run_t run,
    output logic engaged
);

    run_t run_n;
    logic busy_q;
    logic busy_fall;

    assign busy_fall = busy_q && !pec_busy;
    assign engaged   = pec_busy || run_active(run);

    always_comb begin
        run_n = run;
        if (issue_pgm) begin
            run_n = (run == RUN_SUSP) ? RUN_SUSP_PGM : RUN_PGM;
        end else if (issue_ers || issue_resm) begin
            run_n = RUN_ERS;
        end else if (issue_susp) begin
            run_n = RUN_SUSP;
        end else if (busy_fall) begin
            case (run)
                RUN_PGM, RUN_ERS: run_n = RUN_NONE;
                RUN_SUSP_PGM:     run_n = RUN_SUSP;
                default:          run_n = run;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= RUN_NONE;
            busy_q <= 1'b0;
        end else begin
            run    <= run_n;
            busy_q <= pec_busy;
        end
    end

endmodule

// File: rtl/fcs_req_reg.sv
module fcs_req_reg
    import fcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  issue_t        issue,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          pgm_go,
    output logic          ers_go,
    output logic          ers_all,
    output logic          susp_go,
    output logic          resm_go,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pgm_go  <= 1'b0;
            ers_go  <= 1'b0;
            ers_all <= 1'b0;
            susp_go <= 1'b0;
            resm_go <= 1'b0;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            pgm_go  <= issue.pgm;
            ers_go  <= issue.ers;
            ers_all <= issue.ers && issue.chip;
            susp_go <= issue.susp;
            resm_go <= issue.resm;
            if (issue.pgm || issue.ers) begin
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_sequencer.sv
module flash_cmd_sequencer
    import fcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 8,
    parameter logic [AW-1:0] KEY1_ADDR = 'h555,
    parameter logic [AW-1:0] KEY2_ADDR = 'h2AA,
    parameter logic [DW-1:0] KEY1_DATA = 'hAA,
    parameter logic [DW-1:0] KEY2_DATA = 'h55,
    parameter logic [DW-1:0] CMD_RESET   = 'hF0,
    parameter logic [DW-1:0] CMD_IDENT   = 'h90,
    parameter logic [DW-1:0] CMD_PROGRAM = 'hA0,
    parameter logic [DW-1:0] CMD_ERASE   = 'h80,
    parameter logic [DW-1:0] CMD_CHIP    = 'h10,
    parameter logic [DW-1:0] CMD_BLOCK   = 'h30,
    parameter logic [DW-1:0] CMD_SUSPEND = 'hB0,
    parameter logic [DW-1:0] CMD_RESUME  = 'h30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          pec_busy,
    output logic          pgm_go,
    output logic          ers_go,
    output logic          ers_all,
    output logic          susp_go,
    output logic          resm_go,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic [1:0]    read_mode
);

    issue_t issue;
    run_t   run;
    logic   engaged;
    logic   ident;

    fcs_seq_decode #(
        .AW(AW), .DW(DW),
        .KEY1_ADDR(KEY1_ADDR), .KEY2_ADDR(KEY2_ADDR),
        .KEY1_DATA(KEY1_DATA), .KEY2_DATA(KEY2_DATA),
        .CMD_RESET(CMD_RESET), .CMD_IDENT(CMD_IDENT),
        .CMD_PROGRAM(CMD_PROGRAM), .CMD_ERASE(CMD_ERASE),
        .CMD_CHIP(CMD_CHIP), .CMD_BLOCK(CMD_BLOCK),
        .CMD_SUSPEND(CMD_SUSPEND), .CMD_RESUME(CMD_RESUME)
    ) u_decode (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .engaged  (engaged),
        .run_ers  (run == RUN_ERS),
        .run_susp (run == RUN_SUSP),
        .issue    (issue),
        .ident    (ident)
    );

    fcs_run_track u_track (
        .clk        (clk),
        .rst        (rst),
        .pec_busy   (pec_busy),
        .issue_pgm  (issue.pgm),
        .issue_ers  (issue.ers),
        .issue_susp (issue.susp),
        .issue_resm (issue.resm),
        .run        (run),
        .engaged    (engaged)
    );

    fcs_req_reg #(.AW(AW), .DW(DW)) u_req (
        .clk     (clk),
        .rst     (rst),
        .issue   (issue),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pgm_go  (pgm_go),
        .ers_go  (ers_go),
        .ers_all (ers_all),
        .susp_go (susp_go),
        .resm_go (resm_go),
        .op_addr (op_addr),
        .op_data (op_data)
    );

    assign read_mode = (pec_busy || run_active(run)) ? RDM_STATUS
                     : (ident ? RDM_IDENT : RDM_ARRAY);

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int DW = 8,
    parameter logic [DW-1:0] SUSP_CODE = 'hB0
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          pec_busy,
    input logic          pgm_go,
    input logic          ers_go,
    input logic          ers_all,
    input logic          susp_go,
    input logic          resm_go,
    input logic [1:0]    read_mode
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!pgm_go && !ers_go && !susp_go && !resm_go && read_mode != 2'd1));

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pgm_go, ers_go, susp_go, resm_go}));

    // R3
    chip_qualifier_chk: assert property (@(posedge clk) disable iff (rst)
        ers_all |-> ers_go);

    // R6
    status_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        (pgm_go || ers_go || resm_go) |-> (read_mode == 2'd2));

    // R6
    status_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        pec_busy |-> (read_mode == 2'd2));

    // R7
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && pec_busy && wr_data != SUSP_CODE)
            |=> !(pgm_go || ers_go || susp_go || resm_go));

endmodule

bind flash_cmd_sequencer fcs_checker #(.DW(DW), .SUSP_CODE(CMD_SUSPEND)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .pec_busy  (pec_busy),
    .pgm_go    (pgm_go),
    .ers_go    (ers_go),
    .ers_all   (ers_all),
    .susp_go   (susp_go),
    .resm_go   (resm_go),
    .read_mode (read_mode)
);

// File: tb/flash_cmd_sequencer_tb.sv
module flash_cmd_sequencer_tb;

    localparam int AW = 20;
    localparam int DW = 8;
    localparam logic [AW-1:0] K1A = 'h555;
    localparam logic [AW-1:0] K2A = 'h2AA;
    localparam logic [DW-1:0] K1D = 'hAA;
    localparam logic [DW-1:0] K2D = 'h55;
    localparam logic [DW-1:0] C_RESET = 'hF0;
    localparam logic [DW-1:0] C_IDENT = 'h90;
    localparam logic [DW-1:0] C_PGM   = 'hA0;
    localparam logic [DW-1:0] C_ERS   = 'h80;
    localparam logic [DW-1:0] C_CHIP  = 'h10;
    localparam logic [DW-1:0] C_BLOCK = 'h30;
    localparam logic [DW-1:0] C_SUSP  = 'hB0;
    localparam logic [DW-1:0] C_RESM  = 'h30;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          pec_busy = 1'b0;
    logic          pgm_go, ers_go, ers_all, susp_go, resm_go;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic [1:0]    read_mode;

    always #4 clk = ~clk;

    flash_cmd_sequencer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pec_busy(pec_busy), .pgm_go(pgm_go), .ers_go(ers_go), .ers_all(ers_all),
        .susp_go(susp_go), .resm_go(resm_go), .op_addr(op_addr), .op_data(op_data),
        .read_mode(read_mode)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 0;
    int    c_pgm = 0, c_ers = 0, c_all = 0, c_susp = 0, c_resm = 0;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } wr_t;

    // behavioural model: 0 none, 1 program, 2 erase, 3 suspended, 4 program in suspend
    int            m_run = 0;
    bit            m_ident = 0;
    bit            m_busy_prev = 0;
    wr_t           q[$];
    bit            e_pgm, e_ers, e_all, e_susp, e_resm;
    logic [AW-1:0] e_addr = '0;
    logic [DW-1:0] e_data = '0;

    task automatic check(string t, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    task automatic drop_all();
        q.delete();
        m_ident = 0;
    endtask

    task automatic classify();
        int  n = q.size();
        wr_t w = q[n-1];
        bit  k1 = (w.a == K1A) && (w.d == K1D);
        bit  k2 = (w.a == K2A) && (w.d == K2D);
        case (n)
            1: begin
                if (w.d == C_RESET) drop_all();
                else if (m_run == 3 && w.d == C_RESM) begin e_resm = 1; q.delete(); end
                else if (!k1) drop_all();
            end
            2: if (!k2) drop_all();
            3: begin
                if (w.a != K1A) drop_all();
                else if (w.d == C_IDENT) begin m_ident = 1; q.delete(); end
                else if (w.d == C_PGM) begin end
                else if (w.d == C_ERS && m_run != 3) begin end
                else drop_all();
            end
            4: begin
                if (q[2].d == C_PGM) begin e_pgm = 1; drop_all(); end
                else if (!k1) drop_all();
            end
            5: if (!k2) drop_all();
            default: begin
                if (w.d == C_CHIP && w.a == K1A) begin e_ers = 1; e_all = 1; end
                else if (w.d == C_BLOCK) e_ers = 1;
                drop_all();
            end
        endcase
    endtask

    task automatic model_step();
        bit  fall, eng;
        wr_t w;
        e_pgm = 0; e_ers = 0; e_all = 0; e_susp = 0; e_resm = 0;
        if (rst) begin
            m_run = 0; m_ident = 0; m_busy_prev = 0; q.delete();
            e_addr = '0; e_data = '0;
            return;
        end
        fall = m_busy_prev && !pec_busy;
        eng  = pec_busy || m_run == 1 || m_run == 2 || m_run == 4;
        if (wr_en) begin
            if (eng) begin
                q.delete();
                if (wr_data == C_SUSP && m_run == 2) e_susp = 1;
            end else begin
                w.a = wr_addr; w.d = wr_data;
                q.push_back(w);
                classify();
            end
        end
        if (e_pgm) m_run = (m_run == 3) ? 4 : 1;
        else if (e_ers || e_resm) m_run = 2;
        else if (e_susp) m_run = 3;
        else if (fall) begin
            if (m_run == 1 || m_run == 2) m_run = 0;
            else if (m_run == 4) m_run = 3;
        end
        if (e_pgm || e_ers) begin e_addr = wr_addr; e_data = wr_data; end
        m_busy_prev = pec_busy;
    endtask

    always @(posedge clk) begin
        int exp_rm;
        model_step();
        #2;
        if (!done) begin
            exp_rm = (pec_busy || m_run == 1 || m_run == 2 || m_run == 4) ? 2 : int'(m_ident);
            check(tag, "pgm_go", pgm_go, e_pgm);
            check(tag, "ers_go", ers_go, e_ers);
            check(tag, "ers_all", ers_all, e_all);
            check(tag, "susp_go", susp_go, e_susp);
            check(tag, "resm_go", resm_go, e_resm);
            check(tag, "read_mode", read_mode, exp_rm);
            check(tag, "op_addr", op_addr, e_addr);
            check(tag, "op_data", op_data, e_data);
            if (pgm_go)  c_pgm++;
            if (ers_go)  c_ers++;
            if (ers_all) c_all++;
            if (susp_go) c_susp++;
            if (resm_go) c_resm++;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic unlock();
        wr(K1A, K1D);
        wr(K2A, K2D);
    endtask

    task automatic do_pgm(logic [AW-1:0] a, logic [DW-1:0] d);
        unlock(); wr(K1A, C_PGM); wr(a, d);
    endtask

    task automatic do_erase(logic [AW-1:0] a, logic [DW-1:0] conf);
        unlock(); wr(K1A, C_ERS); unlock(); wr(a, conf);
    endtask

    task automatic busy_for(int n);
        @(negedge clk); pec_busy = 1;
        repeat (n) @(negedge clk);
        pec_busy = 0;
        idle(2);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog run did not end actual 0 expected 1");
            finish_up();
        end
    end

    initial begin
        int b;
        wr_t seqv[6];
        idle(3);
        rst = 0;
        idle(2);
        // R1 reset state
        tag = "R1";
        check("R1", "read_mode after reset", read_mode, 0);
        check("R1", "no strobes after reset", c_pgm + c_ers + c_susp + c_resm, 0);

        // R2 program, R6 status while running
        tag = "R2";
        do_pgm('h1234A, 'h5C);
        check("R2", "pgm_go count", c_pgm, 1);
        check("R2", "op_addr", op_addr, 'h1234A);
        check("R2", "op_data", op_data, 'h5C);
        check("R6", "status after program start", read_mode, 2);
        // R9 suspend during program, R7 sequence during busy
        tag = "R9";
        @(negedge clk); pec_busy = 1;
        wr('h00777, C_SUSP);
        check("R9", "susp_go during program", c_susp, 0);
        tag = "R7";
        do_pgm('h00010, 'h11);
        check("R7", "program ignored while busy", c_pgm, 1);
        @(negedge clk); pec_busy = 0;
        idle(2);
        check("R6", "array after busy falls", read_mode, 0);

        // R3 block erase then suspend/resume (R7, R8)
        tag = "R3";
        do_erase('h4C000, C_BLOCK);
        check("R3", "ers_go count", c_ers, 1);
        check("R3", "ers_all for block", c_all, 0);
        check("R3", "op_addr block", op_addr, 'h4C000);
        tag = "R7";
        @(negedge clk); pec_busy = 1;
        idle(3);
        wr('h12345, C_SUSP);
        check("R7", "susp_go during erase", c_susp, 1);
        idle(2);
        @(negedge clk); pec_busy = 0;
        idle(2);
        tag = "R8";
        check("R8", "array while suspended", read_mode, 0);
        do_pgm('h0100F, 'h3E);
        check("R8", "program in suspend", c_pgm, 2);
        busy_for(4);
        check("R8", "back to array in suspend", read_mode, 0);
        do_erase('h20000, C_BLOCK);
        check("R8", "erase rejected in suspend", c_ers, 1);
        wr('h00abc, C_RESM);
        check("R8", "resm_go count", c_resm, 1);
        check("R8", "status after resume", read_mode, 2);
        busy_for(5);
        check("R6", "array after erase ends", read_mode, 0);

        // R3 chip erase
        tag = "R3";
        do_erase(K1A, C_CHIP);
        check("R3", "chip ers_go count", c_ers, 2);
        check("R3", "chip ers_all count", c_all, 1);
        busy_for(3);

        // R5 identifier mode
        tag = "R5";
        unlock(); wr(K1A, C_IDENT);
        check("R5", "ident mode", read_mode, 1);
        idle(3);
        check("R5", "ident persists", read_mode, 1);
        wr('h00003, 'h77);
        check("R4", "stray write leaves ident", read_mode, 0);
        unlock(); wr(K1A, C_IDENT);
        wr('h00000, C_RESET);
        check("R5", "reset command leaves ident", read_mode, 0);

        // R4 one wrong write at each position
        tag = "R4";
        for (int p = 0; p < 6; p++) begin
            seqv[0] = '{K1A, K1D}; seqv[1] = '{K2A, K2D}; seqv[2] = '{K1A, C_ERS};
            seqv[3] = '{K1A, K1D}; seqv[4] = '{K2A, K2D}; seqv[5] = '{'h30000, C_BLOCK};
            seqv[p].d = seqv[p].d ^ 8'h01;
            b = c_ers;
            for (int i = 0; i < 6; i++) wr(seqv[i].a, seqv[i].d);
            check("R4", "erase aborted", c_ers, b);
            check("R4", "array after abort", read_mode, 0);
        end
        for (int p = 0; p < 3; p++) begin
            seqv[0] = '{K1A, K1D}; seqv[1] = '{K2A, K2D}; seqv[2] = '{K1A, C_PGM};
            seqv[p].a = seqv[p].a ^ 20'h00001;
            b = c_pgm;
            for (int i = 0; i < 3; i++) wr(seqv[i].a, seqv[i].d);
            wr('h00044, 'h44);
            check("R4", "program aborted", c_pgm, b);
        end
        do_pgm('h00050, 'h0F);
        check("R4", "clean sequence after aborts", c_pgm, 3);
        busy_for(2);

        // R1 reset in the middle of a sequence
        tag = "R1";
        unlock(); wr(K1A, C_PGM);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        wr('h00060, 'h60);
        check("R1", "sequence cut by reset", c_pgm, 3);
        check("R1", "array after reset", read_mode, 0);

        idle(3);
        finish_up();
    end

endmodule